// File: doc/BRIEF.md
# Up-Counting Scanline Interrupt Generator

This block raises a scanline interrupt for a cartridge bank controller. It watches the video bus for the pattern-table fetch rhythm. One line of rendering shows up as a drop of address bit 12 from 1 to 0 on a read cycle below 0x2000. Each such drop advances an 8-bit counter by one. The counter counts upward, so software that would program a down-counting design with a value N writes N XOR 0xFF into the latch to get the same line.

The CPU reaches four write-only registers, chosen by two address bits: a latch value, a reload strobe, an enable and a disable. When the count reaches its end, a pending flag is set. While the flag is set and interrupts are enabled, the active-low interrupt output is held low. A parameter picks when the flag is raised. One choice raises it on the edge that finds the counter at 255. The other raises it a programmable number of CPU cycles after the counter wraps to 0.

All inputs are sampled on one fast system clock. Read-strobe falls, address-12 history and CPU write strobes are found by comparing each input with its value on the previous clock.

Top module: `scanline_upirq`

## Requirements
- R1: A synchronous reset drives `irq_n` high and clears the counter, latch, pending flag, enable and reload request. With no reload after reset, mode 0 raises on qualifying edge 256. After one reload with the cleared latch, it raises on edge 257.
- R2: A qualifying edge is a fall of `vid_rd_n` with `vid_a13`=0, the previously sampled A12 equal to 1 and the current `vid_a12` equal to 0. The stored A12 is refreshed on every fall of `vid_rd_n`, including falls with `vid_a13`=1. A12 changes while `vid_rd_n` stays high are ignored.
- R3: Falls of `vid_rd_n` with `vid_a13`=1 never advance the counter.
- R4: Each qualifying edge adds one to the counter, and 255 wraps to 0. Back-to-back qualifying edges all count; there is no minimum spacing.
- R5: A write is taken once, on the first clock where `cpu_m2`=1, `cpu_sel`=1 and `cpu_rw`=0. `cpu_addr` selects the register: 0 = latch (8-bit data), 1 = reload and acknowledge, 2 = enable, 3 = disable. With `cpu_sel`=0 nothing is written.
- R6: A reload write makes the next qualifying edge load the latch instead of incrementing. That edge never raises the flag. A reload write on the same clock as a qualifying edge loads on that edge, so the reload wins.
- R7: Mode 0 (`MODE`=0): a qualifying edge that finds the counter at 255, and is not a load edge, sets the pending flag. With latch L, the flag is set on qualifying edge 257−L, counting the load edge as edge 1.
- R8: Mode 1 (`MODE`=1): the wrap edge from R7 starts a delay instead. The flag is set on the `WRAP_DELAY`-th rising edge of `cpu_m2` after the wrap (default 6). An M2 rise on the wrap clock itself is not counted.
- R9: A reload write clears the pending flag. If the flag is raised on the same clock, the raise wins.
- R10: A disable write does not clear the pending flag. A later enable drives `irq_n` low again without any new edge.
- R11: With `LATCH_ACK`=1, a latch write also clears the pending flag. With `LATCH_ACK`=0, it does not.
- R12: `irq_n` is low exactly when the pending flag and the enable are both set. It changes on the same clock edge as they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both buses |
| rst | input | 1 | Synchronous reset, active high |
| cpu_m2 | input | 1 | CPU cycle phase; writes are taken while high |
| cpu_rw | input | 1 | CPU read/write, 0 = write |
| cpu_sel | input | 1 | Register window selected (upper decode and ROM select active) |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | CNT_W | CPU write data |
| vid_rd_n | input | 1 | Video bus read strobe, active low |
| vid_a12 | input | 1 | Video address bit 12 |
| vid_a13 | input | 1 | Video address bit 13 |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
Two events can land on one clock in this block. The first pair is a reload write and a qualifying video edge. The bench drives the CPU write and the read-strobe fall into the same clock while the counter sits at 255. It then expects the latch to be loaded with no interrupt, and the interrupt to come on the next line. The second pair is the delayed raise of the wrap mode and a reload acknowledge. The bench counts M2 rises after a wrap so that the acknowledge write supplies the final rise, and expects the interrupt to remain asserted until a second acknowledge. Full sweeps of the latch value judge the line on which each mode raises against 257−L and 262−L.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    REG_LATCH   = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_ENABLE  = 2'd2,
    REG_DISABLE = 2'd3
  } sirq_reg_e;

  localparam int RAISE_AT_TERM    = 0;
  localparam int RAISE_AFTER_WRAP = 1;

endpackage

// File: rtl/sirq_cpu_regs.sv
module sirq_cpu_regs
  import sirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_m2,
  input  logic             cpu_rw,
  input  logic             cpu_sel,
  input  logic [1:0]       cpu_addr,
  input  logic [CNT_W-1:0] cpu_wdata,
  output logic [CNT_W-1:0] latch_q,
  output logic             en_q,
  output logic             en_next,
  output logic             wr_latch,
  output logic             wr_reload,
  output logic             wr_dis,
  output logic             m2_rise
);

  logic wr_act, wr_q, m2_q, wr_stb, wr_en;

  assign wr_act  = cpu_m2 & cpu_sel & ~cpu_rw;
  assign wr_stb  = wr_act & ~wr_q;
  assign m2_rise = cpu_m2 & ~m2_q;

  always_comb begin
    wr_latch  = 1'b0;
    wr_reload = 1'b0;
    wr_en     = 1'b0;
    wr_dis    = 1'b0;
    if (wr_stb) begin
      case (sirq_reg_e'(cpu_addr))
        REG_LATCH:   wr_latch  = 1'b1;
        REG_RELOAD:  wr_reload = 1'b1;
        REG_ENABLE:  wr_en     = 1'b1;
        REG_DISABLE: wr_dis    = 1'b1;
        default:     wr_latch  = 1'b0;
      endcase
    end
  end

  assign en_next = wr_en ? 1'b1 : (wr_dis ? 1'b0 : en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      m2_q    <= 1'b0;
      latch_q <= '0;
      en_q    <= 1'b0;
    end else begin
      wr_q <= wr_act;
      m2_q <= cpu_m2;
      en_q <= en_next;
      if (wr_latch) latch_q <= cpu_wdata;
    end
  end

endmodule

// File: rtl/sirq_edge_qual.sv
module sirq_edge_qual (
  input  logic clk,
  input  logic rst,
  input  logic vid_rd_n,
  input  logic vid_a12,
  input  logic vid_a13,
  output logic qual
);

  logic rd_q, a12_prev, rd_fall;

  assign rd_fall = rd_q & ~vid_rd_n;
  assign qual    = rd_fall & ~vid_a13 & a12_prev & ~vid_a12;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b1;
      a12_prev <= 1'b0;
    end else begin
      rd_q <= vid_rd_n;
      if (rd_fall) a12_prev <= vid_a12;
    end
  end

endmodule

// File: rtl/sirq_upcounter.sv
module sirq_upcounter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] latch_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             reload_pend,
  output logic             term_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic load;

  assign load     = qual & (reload_pend | wr_reload);
  assign term_hit = qual & ~load & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      reload_pend <= 1'b0;
    end else if (load) begin
      cnt_q       <= latch_q;
      reload_pend <= 1'b0;
    end else if (qual) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (wr_reload) begin
      reload_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/sirq_wrap_delay.sv
module sirq_wrap_delay #(
  parameter int WRAP_DELAY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic m2_rise,
  output logic fire
);

  localparam int DLY_W = $clog2(WRAP_DELAY + 1);
  localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(WRAP_DELAY);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic [DLY_W-1:0] dly_q;

  assign fire = m2_rise & (dly_q == DLY_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
    end else if (start) begin
      dly_q <= DLY_INIT;
    end else if (m2_rise && dly_q != '0) begin
      dly_q <= dly_q - DLY_ONE;
    end
  end

endmodule

// File: rtl/scanline_upirq.sv
module scanline_upirq
  import sirq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MODE       = RAISE_AT_TERM,
  parameter int WRAP_DELAY = 6,
  parameter bit LATCH_ACK  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_m2,
  input  logic             cpu_rw,
  input  logic             cpu_sel,
  input  logic [1:0]       cpu_addr,
  input  logic [CNT_W-1:0] cpu_wdata,
  input  logic             vid_rd_n,
  input  logic             vid_a12,
  input  logic             vid_a13,
  output logic             irq_n
);

  logic [CNT_W-1:0] latch_q, cnt_q;
  logic en_q, en_next, wr_latch, wr_reload, wr_dis, m2_rise;
  logic qual, reload_pend, term_hit, fire, raise;
  logic pend_q, pend_next, clr;

  sirq_cpu_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .cpu_m2(cpu_m2), .cpu_rw(cpu_rw), .cpu_sel(cpu_sel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .latch_q(latch_q), .en_q(en_q),
    .en_next(en_next), .wr_latch(wr_latch), .wr_reload(wr_reload),
    .wr_dis(wr_dis), .m2_rise(m2_rise)
  );

  sirq_edge_qual edge_i (
    .clk(clk), .rst(rst), .vid_rd_n(vid_rd_n), .vid_a12(vid_a12),
    .vid_a13(vid_a13), .qual(qual)
  );

  sirq_upcounter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .qual(qual), .wr_reload(wr_reload), .latch_q(latch_q),
    .cnt_q(cnt_q), .reload_pend(reload_pend), .term_hit(term_hit)
  );

  sirq_wrap_delay #(.WRAP_DELAY(WRAP_DELAY)) dly_i (
    .clk(clk), .rst(rst), .start(term_hit), .m2_rise(m2_rise), .fire(fire)
  );

  generate
    if (MODE == RAISE_AFTER_WRAP) begin : g_after_wrap
      assign raise = fire;
    end else begin : g_at_term
      assign raise = term_hit;
    end
  endgenerate

  assign clr       = wr_reload | (LATCH_ACK & wr_latch);
  assign pend_next = (pend_q & ~clr) | raise;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      pend_q <= pend_next;
      irq_n  <= ~(pend_next & en_next);
    end
  end

endmodule

module sirq_checker #(
  parameter int CNT_W = 8,
  parameter int MODE  = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             qual,
  input logic             wr_reload,
  input logic             wr_latch,
  input logic             wr_dis,
  input logic             reload_pend,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] latch_q,
  input logic             pend_q,
  input logic             en_q,
  input logic             irq_n
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (irq_n && cnt_q == '0 && !pend_q && !en_q && !reload_pend));

  p_hold_no_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !qual |=> $stable(cnt_q));

  p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
    (qual && !reload_pend && !wr_reload) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_reload_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (qual && wr_reload) |=> (cnt_q == $past(latch_q) && !reload_pend));

  p_term_raise_r7: assert property (@(posedge clk) disable iff (rst)
    (MODE == 0 && qual && !reload_pend && !wr_reload && cnt_q == '1) |=> pend_q);

  p_disable_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (pend_q && wr_dis && !wr_reload && !wr_latch) |=> pend_q);

  p_irq_level_r12: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(pend_q && en_q));

endmodule

bind scanline_upirq sirq_checker #(.CNT_W(CNT_W), .MODE(MODE)) chk_i (
  .clk(clk), .rst(rst), .qual(qual), .wr_reload(wr_reload), .wr_latch(wr_latch),
  .wr_dis(wr_dis), .reload_pend(reload_pend), .cnt_q(cnt_q), .latch_q(latch_q),
  .pend_q(pend_q), .en_q(en_q), .irq_n(irq_n)
);

// File: tb/scanline_upirq_tb_top.sv
module scanline_upirq_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, m2 = 1'b0, rw = 1'b1, sel = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic rd_n = 1'b1, a12 = 1'b0, a13 = 1'b0;
  logic irq_a, irq_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  scanline_upirq #(.CNT_W(8), .MODE(0), .WRAP_DELAY(6), .LATCH_ACK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cpu_m2(m2), .cpu_rw(rw), .cpu_sel(sel), .cpu_addr(addr),
    .cpu_wdata(wdata), .vid_rd_n(rd_n), .vid_a12(a12), .vid_a13(a13), .irq_n(irq_a));

  scanline_upirq #(.CNT_W(8), .MODE(1), .WRAP_DELAY(6), .LATCH_ACK(1'b0)) dut_wrap_i (
    .clk(clk), .rst(rst), .cpu_m2(m2), .cpu_rw(rw), .cpu_sel(sel), .cpu_addr(addr),
    .cpu_wdata(wdata), .vid_rd_n(rd_n), .vid_a12(a12), .vid_a13(a13), .irq_n(irq_b));

  // Reference model built from the requirements (R2..R12)
  int m_cnt, m_latch, m_dly;
  bit m_rp, m_pa, m_pb, m_en, m_a12p, m_wrq, m_m2q, m_rdq;

  always @(posedge clk) begin : model
    bit wr, m2r, fall, q, wl, wrl, we, wd, ld, hit, fire;
    if (rst) begin
      m_cnt = 0; m_latch = 0; m_dly = 0; m_rp = 0; m_pa = 0; m_pb = 0;
      m_en = 0; m_a12p = 0; m_wrq = 0; m_m2q = 0; m_rdq = 1;
    end else begin
      wr   = m2 && sel && !rw && !m_wrq;
      m2r  = m2 && !m_m2q;
      fall = m_rdq && !rd_n;
      q    = fall && !a13 && m_a12p && !a12;
      wl   = wr && addr == 2'd0;
      wrl  = wr && addr == 2'd1;
      we   = wr && addr == 2'd2;
      wd   = wr && addr == 2'd3;
      ld   = q && (m_rp || wrl);
      hit  = q && !ld && m_cnt == 255;
      if (ld) begin m_cnt = m_latch; m_rp = 0; end
      else if (q) m_cnt = (m_cnt + 1) % 256;
      else if (wrl) m_rp = 1;
      fire = m2r && m_dly == 1;
      if (hit) m_dly = 6;
      else if (m2r && m_dly != 0) m_dly = m_dly - 1;
      m_pa = (m_pa && !(wrl || wl)) || hit;
      m_pb = (m_pb && !wrl) || fire;
      if (wl) m_latch = wdata;
      if (we) m_en = 1; else if (wd) m_en = 0;
      if (fall) m_a12p = a12;
      m_wrq = m2 && sel && !rw;
      m_m2q = m2;
      m_rdq = rd_n;
    end
  end

  task automatic chk_val(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model(string tag);
    chk_val({tag, " irq_a"}, irq_a, !(m_pa && m_en));
    chk_val({tag, " irq_b"}, irq_b, !(m_pb && m_en));
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d, bit use_sel = 1'b1);
    sel = use_sel; rw = 1'b0; addr = a; wdata = d; m2 = 1'b1;
    @(negedge clk);
    m2 = 1'b0; sel = 1'b0; rw = 1'b1;
    @(negedge clk);
  endtask

  task automatic m2_cycle();
    m2 = 1'b1; @(negedge clk);
    m2 = 1'b0; @(negedge clk);
  endtask

  task automatic vid_fetch(logic v12, logic v13);
    rd_n = 1'b0; a12 = v12; a13 = v13;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic scan_line();
    vid_fetch(1'b1, 1'b0);
    vid_fetch(1'b0, 1'b0);
    m2_cycle();
  endtask

  // runs lines until both raise; compares the raise line with the arithmetic
  task automatic run_lines(int exp_a, int exp_b, string tag);
    int la = -1, lb = -1;
    for (int k = 1; k <= 300 && (la < 0 || lb < 0); k++) begin
      scan_line();
      chk_model({tag, "/R4 per-line"});
      if (la < 0 && irq_a == 1'b0) la = k;
      if (lb < 0 && irq_b == 1'b0) lb = k;
    end
    n_cmp += 2;
    if (la != exp_a) begin
      n_bad++;
      $display("FAIL %s/R7 raise line: actual %0d expected %0d", tag, la, exp_a);
    end
    if (lb != exp_b) begin
      n_bad++;
      $display("FAIL %s/R8 raise line: actual %0d expected %0d", tag, lb, exp_b);
    end
  endtask

  task automatic sweep_one(int lv);
    cpu_wr(2'd0, 8'(lv));
    cpu_wr(2'd1, 8'd0);
    cpu_wr(2'd2, 8'd0);
    run_lines(257 - lv, 262 - lv, "R7 sweep");
  endtask

  initial begin : watchdog
    #(20 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all reqs): actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_val("R1 reset irq_a", irq_a, 1'b1);
    chk_val("R1 reset irq_b", irq_b, 1'b1);

    // R1: counter starts at 0 -> edge 256; latch 0 after reload -> edge 257
    cpu_wr(2'd2, 8'd0);
    run_lines(256, 261, "R1 no-reload");
    cpu_wr(2'd1, 8'd0);
    run_lines(257, 262, "R1 cleared latch");

    // R7/R8/R4: sweep latch values
    for (int lv = 255; lv >= 192; lv--) sweep_one(lv);
    sweep_one(0);
    sweep_one(8'h5A ^ 8'hFF);

    // R3: A13=1 edges do not count
    cpu_wr(2'd0, 8'hFF);
    cpu_wr(2'd1, 8'd0);
    scan_line();
    for (int i = 0; i < 3; i++) begin
      vid_fetch(1'b1, 1'b1);
      vid_fetch(1'b0, 1'b1);
    end
    chk_val("R3 a13 high ignored", irq_a, 1'b1);
    chk_model("R3");
    scan_line();
    chk_val("R3 normal edge raises", irq_a, 1'b0);

    // R2: A12 moves with strobe high are ignored; A12 tracked on a13 reads
    cpu_wr(2'd1, 8'd0);
    scan_line();
    a12 = 1'b1; @(negedge clk);
    a12 = 1'b0; @(negedge clk);
    vid_fetch(1'b0, 1'b0);
    chk_val("R2 a12 without read ignored", irq_a, 1'b1);
    vid_fetch(1'b1, 1'b1);
    vid_fetch(1'b0, 1'b0);
    chk_val("R2 a12 sampled on a13 read", irq_a, 1'b0);
    chk_model("R2");

    // R10 / R5
    cpu_wr(2'd3, 8'd0);
    chk_val("R10 disable masks irq", irq_a, 1'b1);
    cpu_wr(2'd2, 8'd0, 1'b0);
    chk_val("R5 unselected write ignored", irq_a, 1'b1);
    cpu_wr(2'd2, 8'd0);
    chk_val("R10 pending kept across disable", irq_a, 1'b0);

    // R11: latch write acks only with LATCH_ACK=1
    repeat (8) m2_cycle();
    chk_val("R11 wrap-mode pending set", irq_b, 1'b0);
    cpu_wr(2'd0, 8'hFF);
    chk_val("R11 latch write acks", irq_a, 1'b1);
    chk_val("R11 latch write no ack", irq_b, 1'b0);

    // R9: delayed raise on same clock as reload ack -> raise wins
    cpu_wr(2'd1, 8'd0);
    chk_model("R9 ack");
    scan_line();
    scan_line();
    chk_val("R9 term raise mode 0", irq_a, 1'b0);
    repeat (4) m2_cycle();
    chk_val("R8 not yet after 5 rises", irq_b, 1'b1);
    cpu_wr(2'd1, 8'd0);
    chk_val("R9 raise wins over ack", irq_b, 1'b0);
    chk_val("R9 ack clears mode 0", irq_a, 1'b1);
    cpu_wr(2'd1, 8'd0);
    chk_val("R9 second ack clears", irq_b, 1'b1);

    // R6: reload write and qualifying edge on one clock -> reload wins
    scan_line();
    vid_fetch(1'b1, 1'b0);
    sel = 1'b1; rw = 1'b0; addr = 2'd1; m2 = 1'b1;
    rd_n = 1'b0; a12 = 1'b0; a13 = 1'b0;
    @(negedge clk);
    m2 = 1'b0; sel = 1'b0; rw = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk_val("R6 collision loads, no raise", irq_a, 1'b1);
    chk_model("R6");
    vid_fetch(1'b1, 1'b0);
    rd_n = 1'b0; a12 = 1'b0;
    @(negedge clk);
    chk_val("R12 irq on the edge clock", irq_a, 1'b0);
    rd_n = 1'b1;
    @(negedge clk);
    chk_val("R6 next line raises", irq_a, 1'b0);
    chk_model("R12");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule